// File: doc/BRIEF.md
# CCD Vertical Field/Frame Readout Sequencer

This block runs at line rate and sets the vertical timing of an interline colour CCD. It counts lines from a one-cycle line tick supplied by the horizontal timing generator and raises a vertical-sync output on the first line of every vertical period. On one fixed line of each period it opens two readout windows, one for each group of transfer-gate phases, at set clock counts after the line tick. It also places an overflow-drain shutter pulse on a line chosen by a shutter-speed select.

There are two accumulation schemes. The monitoring (field) scheme splits a frame of `FIELD_LINES` lines into two periods: `FIELD_A`, which is `FIELD_LINES/2` lines long, and `FIELD_B`, which holds the remaining lines. Both readout groups fire in each of these periods, so that neighbouring rows are summed into colour lines. The still (frame) scheme uses periods of `FRAME_LINES` lines that alternate between `FRAME_ODD`, where only group A fires, and `FRAME_EVEN`, where only group B fires. The mode request and the shutter select are sampled only on the tick that starts a period. The period that follows a change of scheme is flagged as not valid, because its charge was gathered under the old scheme.

The state machine has four states. Every transition happens on the tick that ends a period:
- With still requested: `FIELD_A`/`FIELD_B`/`FRAME_EVEN` → `FRAME_ODD`, and `FRAME_ODD` → `FRAME_EVEN`.
- With field requested: `FIELD_A` → `FIELD_B`, and `FIELD_B`/`FRAME_ODD`/`FRAME_EVEN` → `FIELD_A`.

Reset enters `FIELD_B` on its last line, so the first tick starts a new period.

Top module: `ccd_vseq`

## Requirements
- R1: While reset is applied and until the first line tick after it, `vsync`, `rd_grp_a`, `rd_grp_b`, `ofd_pulse`, `field_valid`, `still_active` and `frame_cnt` are all 0.
- R2: In field mode the periods alternate `FIELD_A` (`FIELD_LINES/2` lines) and `FIELD_B` (`FIELD_LINES - FIELD_LINES/2` lines). `line_idx` runs from 1 up to the period length, and `vsync` is 1 exactly while `line_idx` is 1.
- R3: In still mode every period is `FRAME_LINES` lines long, and the periods alternate odd and even, starting with odd. `vsync` behaves as in R2.
- R4: Readouts occur only on line `RD_LINE` of a period. Counting the clock cycle after the one in which the tick was sampled as count 0, `rd_grp_a` is high for counts `RD1_START` to `RD1_START+RD_LEN-1` and `rd_grp_b` is high for counts `RD2_START` to `RD2_START+RD_LEN-1`.
- R5: In both field periods, both readout groups fire.
- R6: In a `FRAME_ODD` period only `rd_grp_a` fires, and in a `FRAME_EVEN` period only `rd_grp_b` fires.
- R7: `still_req` and `shutter_sel` are sampled only on the tick that starts a period. A change at any other time does not affect `still_active`, the readout pattern or the shutter line until the next period.
- R8: `field_valid` is 0 for exactly the one period whose scheme (field or still) differs from that of the period before it, and 1 for every other period.
- R9: In every field-mode period, `ofd_pulse` is high for the whole of line `SHUT_BASE + shutter_sel*SHUT_STEP`. It is never high in still mode.
- R10: `frame_cnt` increments, wrapping modulo 2^`FCNT_W`, on each period start that enters `FIELD_A` or `FRAME_ODD`.
- R11: No readout occurs on an optical-black line, that is, on lines 1 to `OB_LINES` of a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_tick | input | 1 | One-cycle pulse at the start of each line |
| still_req | input | 1 | Mode request: 1 selects still (frame), 0 selects monitoring (field) |
| shutter_sel | input | SH_W | Selects the line of the shutter pulse |
| vsync | output | 1 | High during line 1 of each vertical period |
| rd_grp_a | output | 1 | Readout enable for transfer-gate group A |
| rd_grp_b | output | 1 | Readout enable for transfer-gate group B |
| ofd_pulse | output | 1 | Overflow-drain shutter pulse |
| field_valid | output | 1 | The current period's output may be used |
| still_active | output | 1 | The current period uses the still scheme |
| frame_cnt | output | FCNT_W | Count of frames started |
| line_idx | output | LW | Line number within the current period |

## Verification
The period state, the line number, the sampled mode and shutter select, and the validity flag all update on the clock edge that samples `line_tick`. Every line-level output is therefore correct from the first cycle after that edge. The readout enables follow a clock count that is 0 in that same cycle and rises by one each cycle. The bench raises the tick on a falling edge, lowers it on the next falling edge, and from then on compares the outputs on every falling edge, giving each one the count it expects. The mode and shutter inputs are disturbed only after a period has started. Any change they cause would show in that same period, so the checks there catch it.

// File: rtl/ccd_vseq_pkg.sv
package ccd_vseq_pkg;
    typedef enum logic [1:0] {
        VS_FIELD_A    = 2'd0,
        VS_FIELD_B    = 2'd1,
        VS_FRAME_ODD  = 2'd2,
        VS_FRAME_EVEN = 2'd3
    } vs_state_e;
endpackage

// File: rtl/ccd_vseq_fsm.sv
module ccd_vseq_fsm
    import ccd_vseq_pkg::*;
#(
    parameter int FIELD_LINES = 525,
    parameter int FRAME_LINES = 656,
    parameter int RD_LINE     = 5,
    parameter int FCNT_W      = 8,
    parameter int LW          = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_tick,
    input  logic              still_req,
    output logic              period_start,
    output logic [LW-1:0]     line_idx,
    output logic              vsync,
    output logic              field_valid,
    output logic              still_active,
    output logic [FCNT_W-1:0] frame_cnt,
    output logic              read_line,
    output logic [1:0]        grp_en
);
    localparam int LEN_A = FIELD_LINES / 2;
    localparam int LEN_B = FIELD_LINES - LEN_A;

    vs_state_e   state, nxt_state;
    logic [LW-1:0] cur_len;

    // Period length of the current state and the successor chosen at a period boundary
    always_comb begin
        cur_len   = LW'(FRAME_LINES);
        nxt_state = VS_FIELD_A;
        unique case (state)
            VS_FIELD_A: begin
                cur_len   = LW'(LEN_A);
                nxt_state = still_req ? VS_FRAME_ODD : VS_FIELD_B;
            end
            VS_FIELD_B: begin
                cur_len   = LW'(LEN_B);
                nxt_state = still_req ? VS_FRAME_ODD : VS_FIELD_A;
            end
            VS_FRAME_ODD: begin
                nxt_state = still_req ? VS_FRAME_EVEN : VS_FIELD_A;
            end
            VS_FRAME_EVEN: begin
                nxt_state = still_req ? VS_FRAME_ODD : VS_FIELD_A;
            end
        endcase
    end

    assign period_start = line_tick && (line_idx == cur_len);

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state       <= VS_FIELD_B;
            line_idx    <= LW'(LEN_B);
            field_valid <= 1'b0;
            frame_cnt   <= '0;
        end else if (period_start) begin
            state       <= nxt_state;
            line_idx    <= LW'(1);
            field_valid <= (nxt_state[1] == state[1]);
            if (nxt_state == VS_FIELD_A || nxt_state == VS_FRAME_ODD)
                frame_cnt <= frame_cnt + 1'b1;
        end else if (line_tick) begin
            line_idx <= line_idx + 1'b1;
        end
    end

    // Output process
    always_comb begin
        vsync        = rst_n && (line_idx == LW'(1));
        read_line    = rst_n && (line_idx == LW'(RD_LINE));
        still_active = 1'b0;
        grp_en       = 2'b00;
        unique case (state)
            VS_FIELD_A, VS_FIELD_B: grp_en = 2'b11;
            VS_FRAME_ODD: begin
                grp_en       = 2'b01;
                still_active = 1'b1;
            end
            VS_FRAME_EVEN: begin
                grp_en       = 2'b10;
                still_active = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/ccd_vseq_win.sv
module ccd_vseq_win #(
    parameter int RD1_START = 732,
    parameter int RD2_START = 1052,
    parameter int RD_LEN    = 120,
    parameter int PIX_W     = 11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_tick,
    input  logic       read_line,
    input  logic [1:0] grp_en,
    output logic [1:0] rd
);
    logic [PIX_W-1:0] pix;

    // Clock count within the line; it saturates so that it never re-enters a window
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pix <= '1;
        else if (line_tick)
            pix <= '0;
        else if (pix != '1)
            pix <= pix + 1'b1;
    end

    for (genvar g = 0; g < 2; g++) begin : g_win
        localparam int WS = (g == 0) ? RD1_START : RD2_START;
        assign rd[g] = read_line && grp_en[g]
                       && (pix >= PIX_W'(WS)) && (pix < PIX_W'(WS + RD_LEN));
    end
endmodule

// File: rtl/ccd_vseq_shut.sv
module ccd_vseq_shut #(
    parameter int SH_W      = 2,
    parameter int SHUT_BASE = 20,
    parameter int SHUT_STEP = 60,
    parameter int LW        = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            period_start,
    input  logic [SH_W-1:0] shutter_sel,
    input  logic [LW-1:0]   line_idx,
    input  logic            still_active,
    output logic            ofd_pulse
);
    logic [SH_W-1:0] sh_q;
    logic [LW-1:0]   ofd_line;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sh_q <= '0;
        else if (period_start)
            sh_q <= shutter_sel;
    end

    always_comb begin
        ofd_line  = LW'(SHUT_BASE) + LW'(SHUT_STEP) * LW'(sh_q);
        ofd_pulse = rst_n && !still_active && (line_idx == ofd_line);
    end
endmodule

// File: rtl/ccd_vseq.sv
module ccd_vseq #(
    parameter int FIELD_LINES = 525,
    parameter int FRAME_LINES = 656,
    parameter int OB_LINES    = 3,
    parameter int RD_LINE     = 5,
    parameter int RD1_START   = 732,
    parameter int RD2_START   = 1052,
    parameter int RD_LEN      = 120,
    parameter int SH_W        = 2,
    parameter int SHUT_BASE   = 20,
    parameter int SHUT_STEP   = 60,
    parameter int FCNT_W      = 8,
    localparam int MAXL       = (FRAME_LINES > FIELD_LINES) ? FRAME_LINES : FIELD_LINES,
    localparam int LW         = $clog2(MAXL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_tick,
    input  logic              still_req,
    input  logic [SH_W-1:0]   shutter_sel,
    output logic              vsync,
    output logic              rd_grp_a,
    output logic              rd_grp_b,
    output logic              ofd_pulse,
    output logic              field_valid,
    output logic              still_active,
    output logic [FCNT_W-1:0] frame_cnt,
    output logic [LW-1:0]     line_idx
);
    localparam int PIX_W = $clog2(RD2_START + RD_LEN + 1);

    logic       period_start;
    logic       read_line;
    logic [1:0] grp_en;
    logic [1:0] rd;

    ccd_vseq_fsm #(
        .FIELD_LINES(FIELD_LINES), .FRAME_LINES(FRAME_LINES),
        .RD_LINE(RD_LINE), .FCNT_W(FCNT_W), .LW(LW)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .still_req(still_req),
        .period_start(period_start), .line_idx(line_idx), .vsync(vsync),
        .field_valid(field_valid), .still_active(still_active),
        .frame_cnt(frame_cnt), .read_line(read_line), .grp_en(grp_en)
    );

    ccd_vseq_win #(
        .RD1_START(RD1_START), .RD2_START(RD2_START),
        .RD_LEN(RD_LEN), .PIX_W(PIX_W)
    ) u_win (
        .clk(clk), .rst_n(rst_n), .line_tick(line_tick),
        .read_line(read_line), .grp_en(grp_en), .rd(rd)
    );

    ccd_vseq_shut #(
        .SH_W(SH_W), .SHUT_BASE(SHUT_BASE), .SHUT_STEP(SHUT_STEP), .LW(LW)
    ) u_shut (
        .clk(clk), .rst_n(rst_n), .period_start(period_start),
        .shutter_sel(shutter_sel), .line_idx(line_idx),
        .still_active(still_active), .ofd_pulse(ofd_pulse)
    );

    assign rd_grp_a = rd[0];
    assign rd_grp_b = rd[1];
endmodule

// File: rtl/ccd_vseq_chk.sv
module ccd_vseq_chk #(
    parameter int RD_LINE  = 5,
    parameter int OB_LINES = 3,
    parameter int LW       = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          line_tick,
    input logic          vsync,
    input logic          rd_grp_a,
    input logic          rd_grp_b,
    input logic          ofd_pulse,
    input logic          field_valid,
    input logic          still_active,
    input logic [LW-1:0] line_idx
);
    p_vsync_line1_r2: assert property (@(posedge clk) disable iff (!rst_n)
        vsync |-> (line_idx == LW'(1)));

    p_line_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        line_tick |=> ((line_idx == LW'(1)) || (line_idx == LW'($past(line_idx) + 1'b1))));

    p_read_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_grp_a || rd_grp_b) |-> (line_idx == LW'(RD_LINE)));

    p_one_group_r6: assert property (@(posedge clk) disable iff (!rst_n)
        still_active |-> $onehot0({rd_grp_a, rd_grp_b}));

    p_mode_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !line_tick |=> $stable(still_active));

    p_valid_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !line_tick |=> $stable(field_valid));

    p_no_ofd_still_r9: assert property (@(posedge clk) disable iff (!rst_n)
        still_active |-> !ofd_pulse);

    p_no_ob_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_grp_a || rd_grp_b) |-> (line_idx > LW'(OB_LINES)));
endmodule

bind ccd_vseq ccd_vseq_chk #(.RD_LINE(RD_LINE), .OB_LINES(OB_LINES), .LW(LW)) u_chk (
    .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .vsync(vsync),
    .rd_grp_a(rd_grp_a), .rd_grp_b(rd_grp_b), .ofd_pulse(ofd_pulse),
    .field_valid(field_valid), .still_active(still_active), .line_idx(line_idx)
);

// File: tb/ccd_vseq_tb_top.sv
module ccd_vseq_tb_top;
    localparam int FL   = 11;
    localparam int FRL  = 9;
    localparam int OBL  = 1;
    localparam int RDL  = 2;
    localparam int R1S  = 4;
    localparam int R2S  = 10;
    localparam int RLEN = 3;
    localparam int SHB  = 3;
    localparam int SHS  = 1;
    localparam int FCW  = 3;
    localparam int LC   = 16;
    localparam int LWT  = $clog2(((FRL > FL) ? FRL : FL) + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_tick = 1'b0;
    logic still_req = 1'b0;
    logic [0:0] shutter_sel = 1'b0;
    logic vsync, rd_grp_a, rd_grp_b, ofd_pulse, field_valid, still_active;
    logic [FCW-1:0] frame_cnt;
    logic [LWT-1:0] line_idx;

    int total = 0;
    int bad = 0;
    bit done = 0;
    int cur_st = 1;
    int fc = 0;

    always #10 clk = ~clk;

    ccd_vseq #(
        .FIELD_LINES(FL), .FRAME_LINES(FRL), .OB_LINES(OBL), .RD_LINE(RDL),
        .RD1_START(R1S), .RD2_START(R2S), .RD_LEN(RLEN), .SH_W(1),
        .SHUT_BASE(SHB), .SHUT_STEP(SHS), .FCNT_W(FCW)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .still_req(still_req),
        .shutter_sel(shutter_sel), .vsync(vsync), .rd_grp_a(rd_grp_a),
        .rd_grp_b(rd_grp_b), .ofd_pulse(ofd_pulse), .field_valid(field_valid),
        .still_active(still_active), .frame_cnt(frame_cnt), .line_idx(line_idx)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int plen(input int s);
        if (s == 0) return FL / 2;
        if (s == 1) return FL - FL / 2;
        return FRL;
    endfunction

    // One vertical period: requested scheme, shutter select, and whether to disturb the inputs mid-period
    task automatic run_period(input bit req, input int sh, input bit glitch);
        int nst;
        int exp_valid;
        int len;
        if (req) nst = (cur_st == 2) ? 3 : 2;
        else     nst = (cur_st == 0) ? 1 : 0;
        exp_valid = ((nst >= 2) == (cur_st >= 2)) ? 1 : 0;
        if (nst == 0 || nst == 2) fc = (fc + 1) % (1 << FCW);
        len = plen(nst);
        still_req = req;
        shutter_sel = sh[0:0];
        for (int l = 1; l <= len; l++) begin
            line_tick = 1'b1;
            @(negedge clk);
            line_tick = 1'b0;
            if (glitch && l == 2) begin
                still_req = ~req;
                shutter_sel = ~sh[0:0];
            end
            chk(nst >= 2 ? "R3" : "R2", "line_idx", int'(line_idx), l);
            chk(nst >= 2 ? "R3" : "R2", "vsync", int'(vsync), (l == 1) ? 1 : 0);
            chk(glitch ? "R7" : "R3", "still_active", int'(still_active), (nst >= 2) ? 1 : 0);
            chk("R8", "field_valid", int'(field_valid), exp_valid);
            chk("R10", "frame_cnt", int'(frame_cnt), fc);
            chk(glitch ? "R7" : "R9", "ofd_pulse", int'(ofd_pulse),
                (nst < 2 && l == SHB + sh * SHS) ? 1 : 0);
            for (int k = 0; k < LC; k++) begin
                int ea;
                int eb;
                string tg;
                ea = (l == RDL && nst != 3 && k >= R1S && k < R1S + RLEN) ? 1 : 0;
                eb = (l == RDL && nst != 2 && k >= R2S && k < R2S + RLEN) ? 1 : 0;
                if (l <= OBL)      tg = "R11";
                else if (l != RDL) tg = "R4";
                else               tg = (nst >= 2) ? "R6" : "R5";
                chk(tg, "rd_grp_a", int'(rd_grp_a), ea);
                chk(tg, "rd_grp_b", int'(rd_grp_b), eb);
                if (k < LC - 1) @(negedge clk);
            end
        end
        cur_st = nst;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs held low during reset
        chk("R1", "vsync", int'(vsync), 0);
        chk("R1", "rd_any", int'(rd_grp_a | rd_grp_b), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R1: still quiet after release and before the first tick
        chk("R1", "vsync", int'(vsync), 0);
        chk("R1", "rd_grp_a", int'(rd_grp_a), 0);
        chk("R1", "rd_grp_b", int'(rd_grp_b), 0);
        chk("R1", "ofd_pulse", int'(ofd_pulse), 0);
        chk("R1", "field_valid", int'(field_valid), 0);
        chk("R1", "still_active", int'(still_active), 0);
        chk("R1", "frame_cnt", int'(frame_cnt), 0);

        run_period(1'b0, 0, 1'b0);
        run_period(1'b0, 1, 1'b0);
        run_period(1'b0, 1, 1'b1);
        run_period(1'b0, 0, 1'b1);
        run_period(1'b1, 0, 1'b0);
        run_period(1'b1, 1, 1'b0);
        run_period(1'b1, 0, 1'b1);
        run_period(1'b1, 0, 1'b0);
        run_period(1'b0, 1, 1'b0);
        run_period(1'b0, 0, 1'b0);
        run_period(1'b0, 1, 1'b0);
        run_period(1'b1, 0, 1'b0);
        run_period(1'b0, 0, 1'b0);
        run_period(1'b0, 1, 1'b0);
        run_period(1'b0, 0, 1'b0);
        run_period(1'b0, 1, 1'b0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule